// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Segment

This block is the boundary-register slice for a group of bidirectional I/O pads. Each pad owns two scan stages. A direction stage observes and can override the buffer enable. A data stage observes and can override the pad data. Every stage pairs a capture/shift flip-flop, clocked on the rising test clock, with an update flip-flop, clocked on the falling test clock, that holds the value applied to the buffer. The stages of all pads form one serial path from `scan_in` to `scan_out`.

A single data stage serves both directions. The effective buffer enable, meaning the value actually sent to the pad enable, selects what the data stage captures. When the pad drives, the stage captures the core's output data. When the pad is an input, it captures the pad input. A test-drive select chooses the source for the buffer controls: either the update flip-flops (external test) or the core's functional output and enable (sample or bypass). The TAP controller and the instruction decode sit outside the block and supply the strobes.

Top module: `bscan_pad_chain`

## Requirements
- R1: Stage order along the serial path: `scan_in` feeds stage 0. Pad p holds stage 2p (direction) and stage 2p+1 (data). `scan_out` is the capture/shift flip-flop of the last stage, 2·NUM_PADS−1.
- R2: While `tap_shift_n` is 0, every capture/shift flip-flop loads from its upstream neighbour on the rising edge of `tck`.
- R3: While `tap_shift_n` is 1 and `tap_capture` is 1, a rising edge loads the direction stage of pad p with `core_en[p]`. The same edge loads the data stage with `core_out[p]` when `pad_en[p]` is 1, and with `pad_in[p]` when `pad_en[p]` is 0.
- R4: A bit presented on `scan_in` appears on `scan_out` after exactly 2·NUM_PADS rising edges of shifting.
- R5: While `tap_shift_n` is 1 and `tap_capture` is 0, the capture/shift flip-flops hold their values.
- R6: The update flip-flops copy the capture/shift flip-flops on the falling edge of `tck` while `tap_update` is 1. Otherwise they hold, so the buffer controls do not change during shifting or capture.
- R7: With `test_drive` = 1, `pad_en[p]` equals the direction update flip-flop of pad p and `pad_out[p]` equals the data update flip-flop of pad p (1 = drive).
- R8: With `test_drive` = 0, `pad_out` equals `core_out` and `pad_en` equals `core_en`.
- R9: `treset` = 1 clears the update flip-flops at the next falling edge and the capture/shift flip-flops at the next rising edge. After that, in test-drive mode `pad_en` is 0, `pad_out` is 0 and `scan_out` is 0.
- R10: `core_in` always equals `pad_in`, whatever the value of `test_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| treset | input | 1 | Synchronous test reset, active high |
| tap_capture | input | 1 | Capture strobe |
| tap_shift_n | input | 1 | 0 = shift, 1 = capture/hold |
| tap_update | input | 1 | Update strobe, sampled on falling `tck` |
| test_drive | input | 1 | 1 = buffer driven from update flip-flops |
| scan_in | input | 1 | Serial data into stage 0 |
| scan_out | output | 1 | Serial data from the last stage |
| core_out | input | NUM_PADS | Functional output data from the core |
| core_en | input | NUM_PADS | Functional output enable from the core, 1 = drive |
| pad_in | input | NUM_PADS | Value from the input buffers |
| pad_out | output | NUM_PADS | Data to the output buffers |
| pad_en | output | NUM_PADS | Output buffer enable, 1 = drive |
| core_in | output | NUM_PADS | Pad input value returned to the core |

## Verification
The assertions assume that the TAP strobes change only between clock edges and stay steady across the edge that samples them. They also assume `treset` is high from time zero until at least one rising and one falling edge have passed. The bench drives every input two nanoseconds after a rising edge. This leaves each control steady across the following falling edge (update) and rising edge (shift/capture), and it holds reset for several cycles at start. The shift and hold properties are disabled while `treset` is high, because reset rather than the strobes decides the next state then.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Role of a stage inside one pad's segment; the value is its offset.
  typedef enum logic {
    CELL_DIR  = 1'b0,
    CELL_DATA = 1'b1
  } cell_kind_e;

  localparam int STAGES_PER_PAD = 2;

  function automatic int stage_idx(input int pad, input cell_kind_e kind);
    return STAGES_PER_PAD * pad + int'(kind);
  endfunction

endpackage

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage (
  input  logic tck,
  input  logic treset,
  input  logic shift_n,
  input  logic capture,
  input  logic scan_d,
  input  logic obs_d,
  output logic sh_q
);

  // Rising-edge capture/shift flop; shift has priority over capture.
  always_ff @(posedge tck) begin
    if (treset)        sh_q <= 1'b0;
    else if (!shift_n) sh_q <= scan_d;
    else if (capture)  sh_q <= obs_d;
  end

endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage (
  input  logic tck,
  input  logic treset,
  input  logic update,
  input  logic sh_d,
  output logic up_q
);

  // Falling-edge holding flop; outputs stay put while the chain shifts.
  always_ff @(negedge tck) begin
    if (treset)      up_q <= 1'b0;
    else if (update) up_q <= sh_d;
  end

endmodule

// File: rtl/bscan_pad_seg.sv
module bscan_pad_seg (
  input  logic tck,
  input  logic treset,
  input  logic shift_n,
  input  logic capture,
  input  logic update,
  input  logic test_drive,
  input  logic scan_d,
  input  logic core_out,
  input  logic core_en,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_en,
  output logic core_in,
  output logic sh_dir,
  output logic sh_dat,
  output logic up_dir,
  output logic up_dat
);

  logic drive_en;
  logic dat_obs;

  // Direction stage observes the core's enable.
  bscan_shift_stage u_dir_sh (
    .tck    (tck),
    .treset (treset),
    .shift_n(shift_n),
    .capture(capture),
    .scan_d (scan_d),
    .obs_d  (core_en),
    .sh_q   (sh_dir)
  );

  bscan_update_stage u_dir_up (
    .tck   (tck),
    .treset(treset),
    .update(update),
    .sh_d  (sh_dir),
    .up_q  (up_dir)
  );

  // Effective enable picks the data stage's capture source.
  assign drive_en = test_drive ? up_dir : core_en;
  assign dat_obs  = drive_en ? core_out : pad_in;

  bscan_shift_stage u_dat_sh (
    .tck    (tck),
    .treset (treset),
    .shift_n(shift_n),
    .capture(capture),
    .scan_d (sh_dir),
    .obs_d  (dat_obs),
    .sh_q   (sh_dat)
  );

  bscan_update_stage u_dat_up (
    .tck   (tck),
    .treset(treset),
    .update(update),
    .sh_d  (sh_dat),
    .up_q  (up_dat)
  );

  assign pad_en  = drive_en;
  assign pad_out = test_drive ? up_dat : core_out;
  assign core_in = pad_in;

endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain #(
  parameter int NUM_PADS = 4
) (
  input  logic                tck,
  input  logic                treset,
  input  logic                tap_capture,
  input  logic                tap_shift_n,
  input  logic                tap_update,
  input  logic                test_drive,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_en,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_en,
  output logic [NUM_PADS-1:0] core_in
);

  import bscan_pkg::*;

  localparam int STAGES = STAGES_PER_PAD * NUM_PADS;

  logic [NUM_PADS:0]   seg_link;
  logic [STAGES-1:0]   sh_bits;
  logic [STAGES-1:0]   upd_bits;

  assign seg_link[0] = scan_in;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int DI = stage_idx(p, CELL_DIR);
    localparam int TI = stage_idx(p, CELL_DATA);

    bscan_pad_seg u_seg (
      .tck       (tck),
      .treset    (treset),
      .shift_n   (tap_shift_n),
      .capture   (tap_capture),
      .update    (tap_update),
      .test_drive(test_drive),
      .scan_d    (seg_link[p]),
      .core_out  (core_out[p]),
      .core_en   (core_en[p]),
      .pad_in    (pad_in[p]),
      .pad_out   (pad_out[p]),
      .pad_en    (pad_en[p]),
      .core_in   (core_in[p]),
      .sh_dir    (sh_bits[DI]),
      .sh_dat    (sh_bits[TI]),
      .up_dir    (upd_bits[DI]),
      .up_dat    (upd_bits[TI])
    );

    assign seg_link[p+1] = sh_bits[TI];
  end

  assign scan_out = seg_link[NUM_PADS];

endmodule

// File: rtl/bscan_pad_chain_chk.sv
module bscan_pad_chain_chk #(
  parameter int NUM_PADS = 4
) (
  input logic                  tck,
  input logic                  treset,
  input logic                  tap_capture,
  input logic                  tap_shift_n,
  input logic                  tap_update,
  input logic                  test_drive,
  input logic                  scan_in,
  input logic                  scan_out,
  input logic [NUM_PADS-1:0]   core_out,
  input logic [NUM_PADS-1:0]   core_en,
  input logic [NUM_PADS-1:0]   pad_in,
  input logic [NUM_PADS-1:0]   pad_out,
  input logic [NUM_PADS-1:0]   pad_en,
  input logic [NUM_PADS-1:0]   core_in,
  input logic [2*NUM_PADS-1:0] sh_bits,
  input logic [2*NUM_PADS-1:0] upd_bits
);

  localparam int S = 2 * NUM_PADS;

  // R2: shifting moves every stage one place downstream
  a_r2_shift_path: assert property (@(posedge tck) disable iff (treset)
    !tap_shift_n |=> (sh_bits[0] == $past(scan_in)) &&
                     (sh_bits[S-1:1] == $past(sh_bits[S-2:0])));

  // R1: serial output is the last stage
  a_r1_scan_out_tail: assert property (@(posedge tck) disable iff (treset)
    !tap_shift_n |=> scan_out == $past(sh_bits[S-2]));

  // R5: no shift and no capture keeps the chain
  a_r5_hold: assert property (@(posedge tck) disable iff (treset)
    (tap_shift_n && !tap_capture) |=> $stable(sh_bits));

  // R6: update flops change only with the update strobe
  a_r6_update_hold: assert property (@(negedge tck) disable iff (treset)
    !tap_update |=> $stable(upd_bits));

  // R9: reset clears the update flops
  a_r9_reset_clear: assert property (@(negedge tck)
    treset |=> upd_bits == '0);

  // R7 / R8: buffer control sources
  a_r8_passthrough: assert property (@(posedge tck) disable iff (treset)
    !test_drive |-> (pad_out == core_out) && (pad_en == core_en));

  // R10: core always sees the pad
  a_r10_core_in: assert property (@(posedge tck) disable iff (treset)
    core_in == pad_in);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_chk
    // R7: test drive applies the held values
    a_r7_test_drive: assert property (@(posedge tck) disable iff (treset)
      test_drive |-> (pad_en[p] == upd_bits[2*p]) &&
                     (pad_out[p] == upd_bits[2*p+1]));
  end

endmodule

bind bscan_pad_chain bscan_pad_chain_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .tck        (tck),
  .treset     (treset),
  .tap_capture(tap_capture),
  .tap_shift_n(tap_shift_n),
  .tap_update (tap_update),
  .test_drive (test_drive),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .core_out   (core_out),
  .core_en    (core_en),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_en     (pad_en),
  .core_in    (core_in),
  .sh_bits    (sh_bits),
  .upd_bits   (upd_bits)
);

// File: tb/bscan_pad_chain_tb.sv
module bscan_pad_chain_tb;

  localparam int N = 4;
  localparam int S = 2 * N;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic treset, tap_capture, tap_shift_n, tap_update, test_drive, scan_in;
  logic scan_out;
  logic [N-1:0] core_out, core_en, pad_in, pad_out, pad_en, core_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bscan_pad_chain #(.NUM_PADS(N)) u_dut (
    .tck(tck), .treset(treset), .tap_capture(tap_capture),
    .tap_shift_n(tap_shift_n), .tap_update(tap_update),
    .test_drive(test_drive), .scan_in(scan_in), .scan_out(scan_out),
    .core_out(core_out), .core_en(core_en), .pad_in(pad_in),
    .pad_out(pad_out), .pad_en(pad_en), .core_in(core_in)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #2;
  endtask

  // Shift so that stage k ends up holding w[k].
  task automatic load_chain(input logic [S-1:0] w);
    tap_shift_n = 1'b0;
    for (int i = 0; i < S; i++) begin
      scan_in = w[S-1-i];
      tick();
    end
    tap_shift_n = 1'b1;
    scan_in = 1'b0;
  endtask

  task automatic read_chain(output logic [S-1:0] got);
    tap_shift_n = 1'b0;
    scan_in = 1'b0;
    for (int i = 0; i < S; i++) begin
      got[S-1-i] = scan_out;
      tick();
    end
    tap_shift_n = 1'b1;
  endtask

  task automatic do_update();
    tap_update = 1'b1;
    tick();
    tap_update = 1'b0;
  endtask

  function automatic logic [S-1:0] pack(input logic [N-1:0] en,
                                        input logic [N-1:0] dat);
    logic [S-1:0] w;
    for (int p = 0; p < N; p++) begin
      w[2*p]   = en[p];
      w[2*p+1] = dat[p];
    end
    return w;
  endfunction

  task automatic t_reset();
    treset = 1'b1; test_drive = 1'b1;
    repeat (3) tick();
    chk("R9 pad_en after reset", 32'(pad_en), 32'(0));
    chk("R9 pad_out after reset", 32'(pad_out), 32'(0));
    chk("R9 scan_out after reset", 32'(scan_out), 32'(0));
    treset = 1'b0;
    tick();
    chk("R9 pad_en stays off without update", 32'(pad_en), 32'(0));
  endtask

  task automatic t_passthrough();
    test_drive = 1'b0;
    core_out = 4'b1010; core_en = 4'b0110; pad_in = 4'b0011;
    #1;
    chk("R8 pad_out follows core", 32'(pad_out), 32'(4'b1010));
    chk("R8 pad_en follows core", 32'(pad_en), 32'(4'b0110));
    chk("R10 core_in in normal mode", 32'(core_in), 32'(4'b0011));
    core_out = 4'b0101; core_en = 4'b1001; pad_in = 4'b1110;
    #1;
    chk("R8 pad_out second pattern", 32'(pad_out), 32'(4'b0101));
    chk("R8 pad_en second pattern", 32'(pad_en), 32'(4'b1001));
    test_drive = 1'b1;
    #1;
    chk("R10 core_in in test drive", 32'(core_in), 32'(4'b1110));
    tick();
  endtask

  task automatic t_extest();
    test_drive = 1'b1;
    core_out = 4'b0000; core_en = 4'b0000;
    load_chain(pack(4'b1011, 4'b0110));
    chk("R6 no change before update (en)", 32'(pad_en), 32'(0));
    chk("R6 no change before update (dat)", 32'(pad_out), 32'(0));
    do_update();
    chk("R7 pad_en from direction stages", 32'(pad_en), 32'(4'b1011));
    chk("R7 pad_out from data stages", 32'(pad_out), 32'(4'b0110));
    tap_shift_n = 1'b0;
    for (int i = 0; i < S; i++) begin
      scan_in = i[0];
      tick();
      chk("R6 outputs steady while shifting", 32'({pad_en, pad_out}),
          32'({4'b1011, 4'b0110}));
    end
    tap_shift_n = 1'b1;
    load_chain(pack(4'b0101, 4'b1100));
    do_update();
    chk("R7 second pattern pad_en", 32'(pad_en), 32'(4'b0101));
    chk("R7 second pattern pad_out", 32'(pad_out), 32'(4'b1100));
    test_drive = 1'b0; core_out = 4'b0011; core_en = 4'b1111;
    #1;
    chk("R8 core wins when test drive off", 32'({pad_en, pad_out}),
        32'({4'b1111, 4'b0011}));
    tick();
  endtask

  task automatic t_latency();
    load_chain('0);
    tap_shift_n = 1'b0;
    scan_in = 1'b1;
    tick();
    scan_in = 1'b0;
    for (int k = 2; k < S; k++) tick();
    chk("R4 scan_out low one edge early", 32'(scan_out), 32'(0));
    tick();
    chk("R4 scan_out after 2*N edges", 32'(scan_out), 32'(1));
    tick();
    chk("R1 bit leaves after last stage", 32'(scan_out), 32'(0));
    tap_shift_n = 1'b1;
  endtask

  task automatic t_order();
    logic [S-1:0] got;
    logic [S-1:0] w;
    w = 8'b1100_1010;
    load_chain(w);
    read_chain(got);
    chk("R1 R2 chain round trip", 32'(got), 32'(w));
  endtask

  task automatic t_hold();
    logic [S-1:0] got;
    load_chain(8'b0110_1001);
    tap_shift_n = 1'b1; tap_capture = 1'b0;
    for (int i = 0; i < 5; i++) begin
      scan_in = ~i[0];
      core_out = 4'(i); pad_in = ~4'(i);
      tick();
    end
    read_chain(got);
    chk("R5 chain held without strobes", 32'(got), 32'(8'b0110_1001));
  endtask

  task automatic t_capture();
    logic [S-1:0] got;
    logic [S-1:0] exp_w;
    logic [N-1:0] dsel;
    // Normal mode: effective enable is core_en.
    test_drive = 1'b0;
    core_en = 4'b1010; core_out = 4'b0110; pad_in = 4'b1101;
    tap_shift_n = 1'b1; tap_capture = 1'b1;
    tick();
    tap_capture = 1'b0;
    for (int p = 0; p < N; p++) dsel[p] = core_en[p] ? core_out[p] : pad_in[p];
    exp_w = pack(core_en, dsel);
    read_chain(got);
    chk("R3 capture normal mode", 32'(got), 32'(exp_w));
    // Test mode: effective enable comes from held direction bits.
    load_chain(pack(4'b0011, 4'b0000));
    do_update();
    test_drive = 1'b1;
    core_en = 4'b1100; core_out = 4'b1001; pad_in = 4'b0110;
    tap_capture = 1'b1;
    tick();
    tap_capture = 1'b0;
    for (int p = 0; p < N; p++) dsel[p] = pad_en[p] ? core_out[p] : pad_in[p];
    exp_w = pack(4'b1100, 4'b0101);
    read_chain(got);
    chk("R3 capture test mode", 32'(got), 32'(exp_w));
    chk("R3 direction select", 32'(dsel), 32'(4'b0101));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    treset = 1'b1; tap_capture = 1'b0; tap_shift_n = 1'b1; tap_update = 1'b0;
    test_drive = 1'b0; scan_in = 1'b0;
    core_out = '0; core_en = '0; pad_in = '0;
    #2;
    t_reset();
    t_passthrough();
    t_extest();
    t_latency();
    t_order();
    t_hold();
    t_capture();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

endmodule